// File: doc/BRIEF.md
# Quad DAC Double-Buffered Code Registers

This block is the digital register core of a four-channel, 12-bit voltage-output converter. A host shifts a 16-bit frame over a three-wire serial link made of data, clock and an active-low select. Each frame names one channel and carries a 12-bit straight-binary code. Once a frame of the correct length is accepted, it is held in a staging register. Two level-sensitive load inputs then move the code onward. The first moves it into the addressed channel's input register. The second copies every input register into the output (converter) register bank. The four output codes drive the converters.

All serial inputs are sampled in the system clock domain through two-stage synchronizers. The two transparent-when-low load controls are modelled as registers that update on every clock cycle in which their control is low. An asynchronous active-low reset forces both banks of all channels to zero-scale or mid-scale, as chosen by a select input.

Top module: `quad_dac_regs`

## Requirements
- R1: While `rstN` is low and `midScaleSel` is low, every input register and every output register holds 0x000.
- R2: While `rstN` is low and `midScaleSel` is high, every input register and every output register holds 0x800.
- R3: A frame is 16 bits, shifted MSB first on rising `serClk` edges while `serSelN` is low. Bits 15:14 pick the channel (00 = A = `dacCode[0]`, 01 = B, 10 = C, 11 = D). Bits 13:12 carry no meaning. Bits 11:0 are the code. The frame is taken on the rising edge of `serSelN`.
- R4: A frame with any number of serial clocks other than 16 is discarded, and the previously accepted frame stays staged.
- R5: While `inLoadN` is high, every input register keeps its value.
- R6: While `outLoadN` is high, every output code keeps its value.
- R7: While `outLoadN` is low, each output code follows its channel's input register.
- R8: With `inLoadN` and `outLoadN` both low, the staged code reaches the addressed channel's output in the same clock update that writes its input register.
- R9: A load with `inLoadN` low writes only the input register of the staged channel. The other three keep their values.
- R10: Rising `serClk` edges while `serSelN` is high are not counted as frame bits.
- R11: The reset takes effect on the outputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| midScaleSel | input | 1 | Reset code select: 0 = 0x000, 1 = 0x800 |
| serData | input | 1 | Serial frame data |
| serClk | input | 1 | Serial shift clock, sampled by `clk` |
| serSelN | input | 1 | Serial frame select, active low |
| inLoadN | input | 1 | Input register load, transparent while low |
| outLoadN | input | 1 | Output register load, transparent while low |
| dacCode | output | 48 | Four 12-bit output codes, channel A in bits 11:0 |

## Verification
The bench sends frames that are one clock short and one clock long after a valid frame. A receiver that counts badly would load the wrong code instead of leaving the earlier staged code in place. It toggles the serial clock while the select is high. A receiver that counted those edges would reject the following good frame. It sets the ignored bits 13:12 to ones, so a decoder that took the wrong bits would misroute channels. Load patterns with only one control low catch a bank that leaks through while it should hold, and writes that touch one channel catch a decoder that disturbs the others. Reset is checked between clock edges with both select values, and a follow-up load shows that the input bank was reset as well.

// File: rtl/dac_regs_pkg.sv
package dac_regs_pkg;
  localparam int NUM_CH  = 4;
  localparam int CODE_W  = 12;
  localparam int FRAME_W = 16;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);

  // control -> datapath strobes
  typedef struct packed {
    logic              inWr;   // write staged code into addressed input register
    logic              outWr;  // copy input bank to output bank
    logic [CH_W-1:0]   chan;
    logic [CODE_W-1:0] code;
  } loadCtrlT;
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RESET_VAL}};
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx
  import dac_regs_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     serData,
  input  logic     serClk,
  input  logic     serSelN,
  input  logic     inLoadN,
  input  logic     outLoadN,
  output loadCtrlT ctrl
);
  logic sData, sClk, sSel;
  logic clkPrev, selPrev;
  logic clkRise, selRise, frameAccept;
  logic [FRAME_W-1:0] shiftReg;
  logic [CNT_W-1:0]   bitCnt;
  logic               stagedValid;
  logic [CH_W-1:0]    stagedChan;
  logic [CODE_W-1:0]  stagedCode;
  logic               unusedPadBits;

  dac_sync #(.WIDTH(3), .STAGES(2), .RESET_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({serSelN, serClk, serData}),
    .dout ({sSel, sClk, sData})
  );

  assign clkRise     = sClk && !clkPrev;
  assign selRise     = sSel && !selPrev;
  assign frameAccept = selRise && (bitCnt == CNT_W'(FRAME_W));
  assign unusedPadBits = ^shiftReg[FRAME_W-CH_W-1:CODE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev     <= 1'b0;
      selPrev     <= 1'b1;
      shiftReg    <= '0;
      bitCnt      <= '0;
      stagedValid <= 1'b0;
      stagedChan  <= '0;
      stagedCode  <= '0;
    end else begin
      clkPrev <= sClk;
      selPrev <= sSel;
      if (sSel)
        bitCnt <= '0;
      else if (clkRise && bitCnt != CNT_MAX)
        bitCnt <= bitCnt + 1'b1;
      if (!sSel && clkRise)
        shiftReg <= {shiftReg[FRAME_W-2:0], sData};
      if (frameAccept) begin
        stagedValid <= 1'b1;
        stagedChan  <= shiftReg[FRAME_W-1 -: CH_W];
        stagedCode  <= shiftReg[CODE_W-1:0];
      end
    end
  end

  always_comb begin
    ctrl.inWr  = !inLoadN && stagedValid;
    ctrl.outWr = !outLoadN;
    ctrl.chan  = stagedChan;
    ctrl.code  = stagedCode;
  end

  // staged frame only changes on an accepted frame
  p_stage_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !frameAccept |=> ($stable(stagedCode) && $stable(stagedChan)));

  // acceptance is a single-cycle event per select rise
  p_accept_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    frameAccept |=> !frameAccept);

  // no bit counted while select is high
  p_idle_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    sSel |=> (bitCnt == '0));
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_regs_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           midScaleSel,
  input  loadCtrlT                       ctrl,
  output logic [NUM_CH-1:0][CODE_W-1:0]  dacCode
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0]              resetCode;
  logic [NUM_CH-1:0][CODE_W-1:0]  inReg;
  logic [NUM_CH-1:0][CODE_W-1:0]  dacReg;

  assign resetCode = midScaleSel ? MID_CODE : '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic hit;
    assign hit = ctrl.inWr && (ctrl.chan == CH_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    inReg[g] <= resetCode;
      else if (hit) inReg[g] <= ctrl.code;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           dacReg[g] <= resetCode;
      else if (ctrl.outWr) dacReg[g] <= hit ? ctrl.code : inReg[g];
    end

    p_other_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.inWr && ctrl.chan != CH_W'(g)) |=> $stable(inReg[g]));
  end

  assign dacCode = dacReg;

  p_in_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.inWr |=> $stable(inReg));

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.outWr |=> $stable(dacReg));

  p_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.outWr |=> (dacReg == inReg));

  p_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.inWr && ctrl.outWr) |=> (dacReg[$past(ctrl.chan)] == $past(ctrl.code)));
endmodule

// File: rtl/quad_dac_regs.sv
module quad_dac_regs
  import dac_regs_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          midScaleSel,
  input  logic                          serData,
  input  logic                          serClk,
  input  logic                          serSelN,
  input  logic                          inLoadN,
  input  logic                          outLoadN,
  output logic [NUM_CH-1:0][CODE_W-1:0] dacCode
);
  loadCtrlT loadCtrl;

  dac_serial_rx u_rx (
    .clk      (clk),
    .rstN     (rstN),
    .serData  (serData),
    .serClk   (serClk),
    .serSelN  (serSelN),
    .inLoadN  (inLoadN),
    .outLoadN (outLoadN),
    .ctrl     (loadCtrl)
  );

  dac_reg_bank u_bank (
    .clk         (clk),
    .rstN        (rstN),
    .midScaleSel (midScaleSel),
    .ctrl        (loadCtrl),
    .dacCode     (dacCode)
  );
endmodule

// File: tb/quad_dac_regs_tb.sv
module quad_dac_regs_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic midScaleSel = 1'b1;
  logic serData = 1'b0;
  logic serClk = 1'b0;
  logic serSelN = 1'b1;
  logic inLoadN = 1'b1;
  logic outLoadN = 1'b1;
  logic [3:0][11:0] dacCode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [11:0] expIn [4];
  logic [11:0] expOut [4];
  bit          stValid;
  logic [1:0]  stCh;
  logic [11:0] stCode;

  // {pulse inLoadN, pulse outLoadN, frame}
  localparam logic [17:0] VEC [8] = '{
    {2'b11, 16'h0ABC},
    {2'b10, 16'h4123},
    {2'b01, 16'h8FFF},
    {2'b10, 16'hF555},
    {2'b01, 16'hC001},
    {2'b11, 16'hB7FF},
    {2'b11, 16'h6000},
    {2'b11, 16'h3FFF}
  };

  quad_dac_regs u_dut (
    .clk(clk), .rstN(rstN), .midScaleSel(midScaleSel), .serData(serData),
    .serClk(serClk), .serSelN(serSelN), .inLoadN(inLoadN), .outLoadN(outLoadN),
    .dacCode(dacCode)
  );

  always #5 clk = ~clk;

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    for (int c = 0; c < 4; c++) check(tag, dacCode[c], expOut[c]);
  endtask

  task automatic resetModel(input logic [11:0] v);
    for (int c = 0; c < 4; c++) begin
      expIn[c] = v;
      expOut[c] = v;
    end
    stValid = 1'b0;
  endtask

  task automatic sendFrame(input logic [15:0] word, input int nbits);
    @(negedge clk);
    serSelN = 1'b0;
    hold(3);
    for (int i = 0; i < nbits; i++) begin
      serData = (i < 16) ? word[15-i] : 1'b0;
      hold(3);
      serClk = 1'b1;
      hold(3);
      serClk = 1'b0;
    end
    hold(3);
    serSelN = 1'b1;
    hold(12);
    if (nbits == 16) begin
      stValid = 1'b1;
      stCh = word[15:14];
      stCode = word[11:0];
    end
  endtask

  task automatic applyLoads(input bit doIn, input bit doOut);
    @(negedge clk);
    inLoadN = !doIn;
    outLoadN = !doOut;
    hold(4);
    inLoadN = 1'b1;
    outLoadN = 1'b1;
    hold(4);
    if (doIn && stValid) expIn[stCh] = stCode;
    if (doOut) for (int c = 0; c < 4; c++) expOut[c] = expIn[c];
  endtask

  initial begin
    resetModel(12'h800);
    hold(3);
    checkAll("R2 mid-scale reset output bank");
    rstN = 1'b1;
    hold(3);
    applyLoads(1'b1, 1'b1);
    checkAll("R2 mid-scale reset input bank");

    // table walk: R3 R5 R6 R7 R8 R9
    for (int v = 0; v < 8; v++) begin
      sendFrame(VEC[v][15:0], 16);
      applyLoads(VEC[v][17], VEC[v][16]);
      checkAll("R3 R5 R6 R7 R8 R9 vector");
    end

    // R4 short and long frames are discarded
    sendFrame(16'h4222, 16);
    sendFrame(16'h4333, 15);
    applyLoads(1'b1, 1'b1);
    check("R4 short frame discarded", dacCode[1], 12'h222);
    sendFrame(16'h8444, 17);
    applyLoads(1'b1, 1'b1);
    check("R4 long frame discarded", dacCode[2], expOut[2]);
    check("R4 earlier frame kept", dacCode[1], 12'h222);

    // R10 clock edges with select high are ignored
    for (int k = 0; k < 3; k++) begin
      serClk = 1'b1; hold(3);
      serClk = 1'b0; hold(3);
    end
    sendFrame(16'hC9AB, 16);
    applyLoads(1'b1, 1'b1);
    check("R10 idle clocks ignored", dacCode[3], 12'h9AB);
    checkAll("R10 all channels");

    // R8 pass-through lands in the same update as the input write
    sendFrame(16'h0246, 16);
    @(negedge clk);
    inLoadN = 1'b0;
    outLoadN = 1'b0;
    hold(3);
    check("R8 pass-through", dacCode[0], 12'h246);
    inLoadN = 1'b1;
    outLoadN = 1'b1;
    hold(2);
    expIn[0] = 12'h246;
    expOut[0] = 12'h246;

    // R11 / R1 asynchronous zero-scale reset
    midScaleSel = 1'b0;
    @(negedge clk);
    #1 rstN = 1'b0;
    #1;
    resetModel(12'h000);
    checkAll("R11 R1 async zero-scale reset");
    hold(2);
    rstN = 1'b1;
    hold(3);
    applyLoads(1'b1, 1'b1);
    checkAll("R1 input bank zero-scale");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule